// File: doc/BRIEF.md
# Elastic Pipelined Left Shifter

This block shifts a data word left by a variable amount and fills the vacated positions with zeros. The work is spread across one stage per bit of the shift amount. Stage j examines bit j of the amount and moves the word left by 2^j positions when that bit is set. Otherwise it passes the word through unchanged. Each stage forwards the shift amount together with the partly shifted word, so that the stages after it can read their own bits.

Each stage writes into a two-entry buffer, and the next stage reads from that buffer. A stage moves an entry only when its source buffer holds one and its destination buffer has room. The stages therefore advance independently rather than in lockstep.

Both ends of the block use a valid/ready handshake. When the consumer stops taking results, the buffers fill from the output backwards and the input stops accepting. No result is ever dropped. Results leave in the order their requests were accepted.

Top module: `elastic_shifter`

## Requirements
- R1: Every result equals the accepted data word shifted left by the accepted amount, truncated to DATA_W bits and zero-filled. An amount of 0 returns the word unchanged.
- R2: `inReady` is high whenever the first stage buffer has room. A request is taken on a rising edge where both `inValid` and `inReady` are high.
- R3: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` keeps its value on the next cycle.
- R4: Every accepted request produces exactly one result. Results come out in acceptance order, and no result appears without a request.
- R5: On an empty pipeline with `outReady` held high, a request accepted on rising edge k is offered on `outValid` immediately after edge k+SHIFT_W-1. That is a latency of SHIFT_W cycles.
- R6: With requests back to back and `outReady` held high, `inReady` never drops, and consecutive results come out on consecutive cycles.
- R7: With `outReady` held low, the block accepts exactly 2*SHIFT_W requests (two per stage buffer) and then holds `inReady` low.
- R8: A synchronous active-high `rst` empties every buffer. While `rst` is high, `outValid` and `inReady` are 0. On the first cycle after reset, `inReady` is 1 and `outValid` is 0, and no result from before the reset ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can take a request |
| inAmt | input | SHIFT_W | Shift amount |
| inData | input | DATA_W | Word to shift |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outData | output | DATA_W | Shifted word |

## Verification
A result is due SHIFT_W cycles after its request is accepted, but only when nothing stalls. Under random bubbles and random stalls it is due at some later time that cannot be predicted. For that reason the scoreboard matches results by order, not by cycle. It pushes each expected word at the moment the handshake is seen to succeed, and pops one on every cycle where `outValid` and `outReady` are both high.

Fixed timing is checked only where it is defined. On an empty pipeline, the bench counts the falling edges from acceptance until `outValid` appears and expects exactly SHIFT_W. In a back-to-back run, it expects the first and last of 20 results to be 19 cycles apart. During a stall, each sample is compared with the previous one to confirm the held value.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  // Entries held between two neighbouring stages.
  localparam int SLOT_DEPTH = 2;

  // Strobes the control hands to the datapath for one stage buffer.
  typedef struct packed {
    logic push;   // write the stage result this cycle
    logic wrSel;  // slot receiving the write
    logic rdSel;  // slot presented as buffer head
  } slotCtl_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic                    outReady,
  output logic                    inReady,
  output logic                    outValid,
  output slotCtl_t [STAGES-1:0]   ctl
);

  localparam int LAST = STAGES - 1;
  localparam logic [1:0] FULL_CNT = 2'(SLOT_DEPTH);

  logic [1:0]        occ   [STAGES];
  logic              wrPtr [STAGES];
  logic              rdPtr [STAGES];
  logic [STAGES-1:0] hasData;
  logic [STAGES-1:0] hasRoom;
  logic [STAGES-1:0] push;
  logic [STAGES-1:0] pop;

  for (genvar j = 0; j < STAGES; j++) begin : g_slot
    assign hasData[j] = (occ[j] != 2'd0);
    assign hasRoom[j] = (occ[j] != FULL_CNT);

    if (j == 0) begin : g_head
      assign push[j] = inValid & hasRoom[j] & ~rst;
    end else begin : g_mid
      // Stage j moves an entry when its source holds one and its buffer has room.
      assign push[j]  = hasData[j-1] & hasRoom[j];
      assign pop[j-1] = push[j];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        occ[j]   <= 2'd0;
        wrPtr[j] <= 1'b0;
        rdPtr[j] <= 1'b0;
      end else begin
        occ[j] <= occ[j] + {1'b0, push[j]} - {1'b0, pop[j]};
        if (push[j]) wrPtr[j] <= ~wrPtr[j];
        if (pop[j])  rdPtr[j] <= ~rdPtr[j];
      end
    end

    assign ctl[j] = '{push: push[j], wrSel: wrPtr[j], rdSel: rdPtr[j]};
  end

  assign pop[LAST] = hasData[LAST] & outReady & ~rst;
  assign inReady   = hasRoom[0] & ~rst;
  assign outValid  = hasData[LAST] & ~rst;

endmodule

// File: rtl/shift_data.sv
module shift_data
  import shifter_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic [STAGES-1:0]      inAmt,
  input  logic [DATA_W-1:0]      inData,
  input  slotCtl_t [STAGES-1:0]  ctl,
  output logic [DATA_W-1:0]      outData
);

  logic [STAGES-1:0] amtMem  [STAGES][SLOT_DEPTH];
  logic [DATA_W-1:0] datMem  [STAGES][SLOT_DEPTH];
  logic [STAGES-1:0] headAmt [STAGES];
  logic [DATA_W-1:0] headDat [STAGES];
  logic [STAGES-1:0] srcAmt  [STAGES];
  logic [DATA_W-1:0] srcDat  [STAGES];
  logic [DATA_W-1:0] stepDat [STAGES];

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    localparam int DIST = 2 ** j;

    if (j == 0) begin : g_src_in
      assign srcAmt[j] = inAmt;
      assign srcDat[j] = inData;
    end else begin : g_src_buf
      assign srcAmt[j] = headAmt[j-1];
      assign srcDat[j] = headDat[j-1];
    end

    // Conditional shift by 2^j, selected by amount bit j.
    assign stepDat[j] = srcAmt[j][j] ? (srcDat[j] << DIST) : srcDat[j];

    always_ff @(posedge clk) begin
      if (ctl[j].push) begin
        amtMem[j][ctl[j].wrSel] <= srcAmt[j];
        datMem[j][ctl[j].wrSel] <= stepDat[j];
      end
    end

    assign headAmt[j] = amtMem[j][ctl[j].rdSel];
    assign headDat[j] = datMem[j][ctl[j].rdSel];
  end

  assign outData = headDat[STAGES-1];

endmodule

// File: rtl/elastic_shifter.sv
module elastic_shifter
  import shifter_pkg::*;
#(
  parameter int SHIFT_W = 4,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [SHIFT_W-1:0] inAmt,
  input  logic [DATA_W-1:0]  inData,
  output logic               outValid,
  input  logic               outReady,
  output logic [DATA_W-1:0]  outData
);

  slotCtl_t [SHIFT_W-1:0] ctl;

  shift_ctrl #(.STAGES(SHIFT_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  shift_data #(.STAGES(SHIFT_W), .DATA_W(DATA_W)) uData (
    .clk     (clk),
    .inAmt   (inAmt),
    .inData  (inData),
    .ctl     (ctl),
    .outData (outData)
  );

endmodule

// File: rtl/shift_checker.sv
module shift_checker #(
  parameter int SHIFT_W = 4,
  parameter int DATA_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  int inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= 0;
    else inFlight <= inFlight + int'(inValid && inReady) - int'(outValid && outReady);
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    inFlight <= 2 * SHIFT_W); // R7

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inFlight != 0); // R4

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    inFlight == 0 |-> inReady); // R2

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid && inReady); // R8

endmodule

bind elastic_shifter shift_checker #(.SHIFT_W(SHIFT_W), .DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/sim_elastic_shifter.sv
module sim_elastic_shifter;

  localparam int SW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic          inReady;
  logic [SW-1:0] inAmt;
  logic [DW-1:0] inData;
  logic          outValid;
  logic          outReady;
  logic [DW-1:0] outData;

  bit            randReady = 1'b0;
  bit            randBit   = 1'b1;
  bit            forceReady = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  int outSeen = 0;
  int runBase = -1;
  int firstCyc = 0;
  int lastCyc = 0;
  int sendWaits = 0;
  bit prevStall = 1'b0;
  logic [DW-1:0] prevData;
  logic [DW-1:0] expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  assign outReady = randReady ? randBit : forceReady;

  elastic_shifter #(.SHIFT_W(SW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inAmt(inAmt), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1 randBit <= ($urandom % 4) != 0;
  end

  // Monitor: pops the scoreboard on each completed output handshake.
  always @(negedge clk) begin
    logic [DW-1:0] e;
    cycle++;
    if (rst) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall) begin
        chk(outValid && outData == prevData, "R3 hold", {15'b0, outValid, outData}, {16'h1, prevData});
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4 unexpected result", 32'(outData), 32'h0);
        end else begin
          e = expQ.pop_front();
          chk(outData == e, "R1 R4 result", 32'(outData), 32'(e));
        end
        if (outSeen == runBase) firstCyc = cycle;
        lastCyc = cycle;
        outSeen++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  task automatic send(input logic [SW-1:0] a, input logic [DW-1:0] d);
    bit took;
    inAmt = a;
    inData = d;
    inValid = 1'b1;
    do begin
      took = inReady;
      if (took) expQ.push_back(DW'(d << a));
      sendWaits++;
      @(negedge clk);
    end while (!took);
    inValid = 1'b0;
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && expQ.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R4 all results delivered", 32'(expQ.size()), 32'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int acc;
    rst = 1'b1;
    inValid = 1'b0;
    inAmt = '0;
    inData = '0;
    repeat (3) @(negedge clk);
    // R8: both handshake outputs low in reset
    chk(!outValid, "R8 outValid in reset", 32'(outValid), 32'h0);
    chk(!inReady, "R8 inReady in reset", 32'(inReady), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(inReady && !outValid, "R8 after reset", {30'b0, inReady, outValid}, 32'h2);

    // R1: every amount with two patterns, back to back
    forceReady = 1'b1;
    for (int a = 0; a < 16; a++) send(SW'(a), 16'hA5C3);
    for (int a = 0; a < 16; a++) send(SW'(a), 16'hFFFF);
    drain(200);

    // R5: latency on an empty pipeline
    send(4'd3, 16'h0001);
    n = 1;
    while (!outValid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == SW, "R5 latency", 32'(n), 32'(SW));
    drain(50);

    // R6: back-to-back throughput
    runBase = outSeen;
    sendWaits = 0;
    for (int i = 0; i < 20; i++) send(SW'(i), DW'(16'h1357 + i));
    chk(sendWaits == 20, "R6 no input stall", 32'(sendWaits), 32'd20);
    drain(100);
    chk(lastCyc - firstCyc == 19, "R6 result spacing", 32'(lastCyc - firstCyc), 32'd19);

    // R7: capacity under a full stall, then R3 hold and R4 order on release
    forceReady = 1'b0;
    acc = 0;
    inValid = 1'b1;
    inAmt = 4'd5;
    inData = 16'h0101;
    for (int i = 0; i < 6 * SW; i++) begin
      if (inReady) begin
        expQ.push_back(DW'(inData << inAmt));
        acc++;
      end
      @(negedge clk);
      inData = inData + 16'h0011;
      inAmt = inAmt + 4'd3;
    end
    inValid = 1'b0;
    chk(acc == 2 * SW, "R7 accepted under stall", 32'(acc), 32'(2 * SW));
    chk(!inReady, "R7 inReady low when full", 32'(inReady), 32'h0);
    chk(outValid, "R3 result offered during stall", 32'(outValid), 32'h1);
    forceReady = 1'b1;
    drain(100);

    // R8: reset while holding results discards them all
    forceReady = 1'b0;
    for (int i = 0; i < 5; i++) send(SW'(i + 1), DW'(16'h8001 + i));
    repeat (SW) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!outValid, "R8 outValid during reset", 32'(outValid), 32'h0);
    expQ.delete();
    rst = 1'b0;
    @(negedge clk);
    chk(inReady && !outValid, "R8 empty after reset", {30'b0, inReady, outValid}, 32'h2);
    forceReady = 1'b1;
    repeat (3 * SW) @(negedge clk);
    chk(!outValid, "R8 no stale result", 32'(outValid), 32'h0);

    // R1 R2 R4: random traffic with bubbles and random stalls
    randReady = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) @(negedge clk);
      send(SW'($urandom), DW'($urandom));
    end
    drain(3000);

    finish_run();
  end

endmodule